// File: doc/BRIEF.md
# Pipelined Write-Hit Controller

This block fronts a direct-mapped cache of 64 lines, each four 32-bit words wide, and accepts a stream of read and write requests. Each request is handled over two stages. In the first stage its tag is compared against the tag store. In the second stage a confirmed write hit actually updates the data array. The data write of one request therefore overlaps the tag compare of the next, and write hits complete at a rate of one per cycle with no stall.

A write hit is not committed at once. It is parked for one cycle in a delayed-write register, which holds its line index, word select, byte enables and data. A read that lands on the parked word in that cycle gets the parked bytes merged over the stale array word. A request whose tag does not match is answered with a miss and leaves the data array untouched. A separate fill port installs a tag on a line so that later requests can hit. Refill of data and the choice of a victim belong to other blocks.

Requests use a valid/ready handshake. Every accepted request gets exactly one response one cycle later. Addresses are word addresses: bits [1:0] select the word in the line, bits [7:2] select the line, and bits [29:8] are the tag.

Top module: `write_hit_pipe`

## Requirements
- R1: While reset is high and in the first cycle after it, resp_valid is 0. After reset no line holds a valid tag, so every request misses. Every data word reads as zero once its tag is installed.
- R2: req_ready is 0 in any cycle where fill_valid is 1, and a request offered in that cycle is not accepted (no response follows). A fill writes fill_line[27:6] as the tag of line fill_line[5:0] and marks that line valid from the next cycle on.
- R3: A request accepted at a clock edge produces resp_valid=1 in the following cycle. That response has exactly one of resp_hit or resp_miss set, and no response appears without an accepted request.
- R4: A write hit (req_op=1) is committed to the data array at the edge one cycle after it is accepted. A read of that word two or more cycles later returns the written bytes.
- R5: A write whose tag misses raises resp_miss and changes no data word.
- R6: Write hits offered on consecutive cycles are all accepted without a gap, and each one lands in the array.
- R7: A read hit (req_op=0) to the same line and word as the write held in the delayed-write register returns the held bytes merged over the array word.
- R8: Only the bytes whose req_be bit is set (bit n covers data bits 8n+7..8n) are changed by a write. The other bytes keep their earlier value.
- R9: A read miss reports resp_miss=1 and resp_rdata=0.
- R10: A read of a different word of the line whose write is held is not affected by the held write.
- R11: Installing a new tag on a line makes requests carrying the old tag miss. Requests with the new tag hit and see the line's existing data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 30 | Word address {tag, line, word} |
| req_be | input | 4 | Byte enables for a write |
| req_wdata | input | 32 | Write data |
| fill_valid | input | 1 | Install a tag this cycle |
| fill_line | input | 28 | {tag, line} to install |
| resp_valid | output | 1 | Response for the request accepted last cycle |
| resp_hit | output | 1 | Tag matched |
| resp_miss | output | 1 | Tag did not match |
| resp_rdata | output | 32 | Read data on a read hit, else zero |

## Verification
The two-stage path is driven with back-to-back streams that mix several patterns. These include a read right behind a write to the same word, which shows whether the bypass is taken. A read two cycles behind a write shows whether the array commit really happened. A read behind a write to a neighbouring word shows whether the bypass is too broad. Partial byte-enable writes stacked on a word separate a correct byte merge from a whole-word overwrite. A write miss followed by a read of its target shows whether a miss leaks into the array. Directed steps cover reset, the ready drop during a fill, and a tag replacement that must turn former hits into misses.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int NUM_LINES  = 64;
    localparam int LINE_WORDS = 4;

    localparam int BE_W    = DATA_W / 8;
    localparam int BOFF_W  = $clog2(BE_W);
    localparam int WADDR_W = ADDR_W - BOFF_W;
    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = WADDR_W - IDX_W - WSEL_W;
    localparam int FILL_W  = TAG_W + IDX_W;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WSEL_W-1:0]  wsel_t;
    typedef logic [BE_W-1:0]    be_t;
    typedef logic [DATA_W-1:0]  data_t;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        wsel_t wsel;
    } loc_t;

    typedef struct packed {
        logic  live;
        idx_t  idx;
        wsel_t wsel;
        be_t   be;
        data_t data;
    } pend_t;

    function automatic loc_t locate(waddr_t a);
        loc_t l;
        l.tag  = a[WADDR_W-1 -: TAG_W];
        l.idx  = a[WSEL_W +: IDX_W];
        l.wsel = a[WSEL_W-1:0];
        return l;
    endfunction

    function automatic data_t byte_merge(data_t base, data_t upd, be_t be);
        data_t r;
        r = base;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fill_en_i,
    input  tag_t fill_tag_i,
    input  idx_t fill_idx_i,
    input  tag_t look_tag_i,
    input  idx_t look_idx_i,
    output logic look_hit_o
);

    logic [NUM_LINES-1:0] vld_w;
    tag_t                 tag_w [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic sel;
        logic v_q;
        tag_t t_q;

        assign sel = fill_en_i && (fill_idx_i == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst)      v_q <= 1'b0;
            else if (sel) v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst)      t_q <= '0;
            else if (sel) t_q <= fill_tag_i;
        end

        assign vld_w[g] = v_q;
        assign tag_w[g] = t_q;
    end

    assign look_hit_o = vld_w[look_idx_i] && (tag_w[look_idx_i] == look_tag_i);

    // R2: a fill leaves its line valid and carrying the installed tag
    a_r2_fill_installs_tag: assert property (@(posedge clk) disable iff (rst)
        fill_en_i |=> (vld_w[$past(fill_idx_i)] && tag_w[$past(fill_idx_i)] == $past(fill_tag_i)));

endmodule

// File: rtl/wpc_data_array.sv
module wpc_data_array
    import wpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we_i,
    input  idx_t  widx_i,
    input  wsel_t wsel_i,
    input  be_t   be_i,
    input  data_t wdata_i,
    input  idx_t  ridx_i,
    input  wsel_t rsel_i,
    output data_t rdata_o
);

    data_t mem_q [NUM_LINES][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                for (int w = 0; w < LINE_WORDS; w++) begin
                    mem_q[l][w] <= '0;
                end
            end
        end else if (we_i) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be_i[b]) mem_q[widx_i][wsel_i][8*b +: 8] <= wdata_i[8*b +: 8];
            end
        end
    end

    assign rdata_o = mem_q[ridx_i][rsel_i];

endmodule

// File: rtl/wpc_pend_reg.sv
module wpc_pend_reg
    import wpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pend_t load_i,
    input  idx_t  look_idx_i,
    input  wsel_t look_wsel_i,
    input  data_t arr_data_i,
    output pend_t pend_o,
    output logic  fwd_hit_o,
    output data_t fwd_data_o
);

    pend_t q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= load_i;
    end

    assign pend_o     = q;
    assign fwd_hit_o  = q.live && (q.idx == look_idx_i) && (q.wsel == look_wsel_i);
    assign fwd_data_o = fwd_hit_o ? byte_merge(arr_data_i, q.data, q.be) : arr_data_i;

endmodule

// File: rtl/write_hit_pipe.sv
module write_hit_pipe
    import wpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [BE_W-1:0]    req_be,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               fill_valid,
    input  logic [FILL_W-1:0]  fill_line,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic               resp_miss,
    output logic [DATA_W-1:0]  resp_rdata
);

    loc_t  rl;
    logic  fire;
    logic  is_wr;
    logic  tag_hit;
    pend_t pend_d;
    pend_t pend_q;
    logic  fwd_hit;
    data_t arr_rd;
    data_t fwd_data;

    assign rl        = locate(req_waddr);
    assign req_ready = !fill_valid;
    assign fire      = req_valid && req_ready;
    assign is_wr     = (op_e'(req_op) == OP_WR);

    wpc_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .fill_en_i  (fill_valid),
        .fill_tag_i (fill_line[IDX_W +: TAG_W]),
        .fill_idx_i (fill_line[IDX_W-1:0]),
        .look_tag_i (rl.tag),
        .look_idx_i (rl.idx),
        .look_hit_o (tag_hit)
    );

    // Stage one: a confirmed write hit goes to the delayed-write register
    always_comb begin
        pend_d.live = fire && is_wr && tag_hit;
        pend_d.idx  = rl.idx;
        pend_d.wsel = rl.wsel;
        pend_d.be   = req_be;
        pend_d.data = req_wdata;
    end

    wpc_pend_reg u_pend (
        .clk         (clk),
        .rst         (rst),
        .load_i      (pend_d),
        .look_idx_i  (rl.idx),
        .look_wsel_i (rl.wsel),
        .arr_data_i  (arr_rd),
        .pend_o      (pend_q),
        .fwd_hit_o   (fwd_hit),
        .fwd_data_o  (fwd_data)
    );

    // Stage two: the held write is committed while the next tag is compared
    wpc_data_array u_data (
        .clk     (clk),
        .rst     (rst),
        .we_i    (pend_q.live),
        .widx_i  (pend_q.idx),
        .wsel_i  (pend_q.wsel),
        .be_i    (pend_q.be),
        .wdata_i (pend_q.data),
        .ridx_i  (rl.idx),
        .rsel_i  (rl.wsel),
        .rdata_o (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= fire;
            resp_hit   <= fire && tag_hit;
            resp_miss  <= fire && !tag_hit;
            resp_rdata <= (fire && !is_wr && tag_hit) ? fwd_data : '0;
        end
    end

    // R1: nothing is answered in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !resp_valid);

    // R3: no response without an accepted request
    a_r3_no_resp_without_accept: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !resp_valid);

    // R4: the array is only written for a write that hit one cycle earlier
    a_r4_array_write_follows_hit: assert property (@(posedge clk) disable iff (rst)
        pend_q.live |-> $past(fire && is_wr && tag_hit));

    // R5: a write miss never reaches the delayed-write register
    a_r5_miss_leaves_no_pending: assert property (@(posedge clk) disable iff (rst)
        (fire && is_wr && !tag_hit) |=> !pend_q.live);

    // R6: every write hit is held for commit, for the word it addressed
    a_r6_hit_enters_pending: assert property (@(posedge clk) disable iff (rst)
        (fire && is_wr && tag_hit) |=> (pend_q.live && pend_q.idx == $past(rl.idx)
                                        && pend_q.wsel == $past(rl.wsel)));

    // R7: a read on the held word takes the forwarded value
    a_r7_bypass_used: assert property (@(posedge clk) disable iff (rst)
        (fire && !is_wr && tag_hit && fwd_hit) |=>
            resp_rdata == $past(byte_merge(arr_rd, pend_q.data, pend_q.be)));

endmodule

// File: tb/write_hit_pipe_bench.sv
module write_hit_pipe_bench;
    import wpc_pkg::*;

    typedef struct packed {
        logic        op;
        logic [21:0] tag;
        logic [5:0]  idx;
        logic [1:0]  wsel;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        exp_hit;
        logic [31:0] exp_rdata;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        {1'b1, 22'd5, 6'd1, 2'd0, 4'hF, 32'h11111111, 1'b1, 32'h00000000}, // R4 write
        {1'b0, 22'd5, 6'd1, 2'd0, 4'h0, 32'h0,        1'b1, 32'h11111111}, // R7 bypass
        {1'b0, 22'd5, 6'd1, 2'd0, 4'h0, 32'h0,        1'b1, 32'h11111111}, // R4 array
        {1'b1, 22'd5, 6'd1, 2'd1, 4'h3, 32'hAAAABBBB, 1'b1, 32'h00000000}, // R8
        {1'b0, 22'd5, 6'd1, 2'd1, 4'h0, 32'h0,        1'b1, 32'h0000BBBB}, // R7 R8
        {1'b1, 22'd5, 6'd1, 2'd1, 4'hC, 32'hCCCCDDDD, 1'b1, 32'h00000000}, // R8
        {1'b0, 22'd5, 6'd1, 2'd1, 4'h0, 32'h0,        1'b1, 32'hCCCCBBBB}, // R7 merge
        {1'b1, 22'd9, 6'd1, 2'd2, 4'hF, 32'hDEADBEEF, 1'b0, 32'h00000000}, // R5 miss
        {1'b0, 22'd5, 6'd1, 2'd2, 4'h0, 32'h0,        1'b1, 32'h00000000}, // R5 untouched
        {1'b1, 22'd7, 6'd2, 2'd3, 4'hF, 32'h12345678, 1'b1, 32'h00000000}, // R6
        {1'b1, 22'd7, 6'd2, 2'd3, 4'hF, 32'h9ABCDEF0, 1'b1, 32'h00000000}, // R6
        {1'b0, 22'd7, 6'd2, 2'd2, 4'h0, 32'h0,        1'b1, 32'h00000000}, // R10
        {1'b0, 22'd7, 6'd2, 2'd3, 4'h0, 32'h0,        1'b1, 32'h9ABCDEF0}, // R6
        {1'b0, 22'd3, 6'd3, 2'd0, 4'h0, 32'h0,        1'b0, 32'h00000000}, // R9
        {1'b0, 22'd5, 6'd1, 2'd0, 4'h0, 32'h0,        1'b1, 32'h11111111}  // R4
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic               req_ready;
    logic               req_op;
    logic [WADDR_W-1:0] req_waddr;
    logic [BE_W-1:0]    req_be;
    logic [DATA_W-1:0]  req_wdata;
    logic               fill_valid;
    logic [FILL_W-1:0]  fill_line;
    logic               resp_valid;
    logic               resp_hit;
    logic               resp_miss;
    logic [DATA_W-1:0]  resp_rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    logic done  = 1'b0;

    always #4 clk = ~clk;

    write_hit_pipe u_write_hit_pipe (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_waddr  (req_waddr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_miss  (resp_miss),
        .resp_rdata (resp_rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic op, input logic [21:0] tag, input logic [5:0] idx,
                         input logic [1:0] wsel, input logic [3:0] be, input logic [31:0] d);
        req_valid = 1'b1;
        req_op    = op;
        req_waddr = {tag, idx, wsel};
        req_be    = be;
        req_wdata = d;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_op    = 1'b0;
        req_waddr = '0;
        req_be    = '0;
        req_wdata = '0;
    endtask

    task automatic fill(input logic [21:0] tag, input logic [5:0] idx);
        fill_valid = 1'b1;
        fill_line  = {tag, idx};
        @(negedge clk);
        fill_valid = 1'b0;
        fill_line  = '0;
    endtask

    task automatic expect_resp(input string req, input logic hit, input logic [31:0] rd);
        chk(req, "resp_valid", 32'(resp_valid), 32'd1);
        chk(req, "resp_hit",   32'(resp_hit),   32'(hit));
        chk(req, "resp_miss",  32'(resp_miss),  32'(!hit));
        chk(req, "resp_rdata", resp_rdata,      rd);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst        = 1'b1;
        fill_valid = 1'b0;
        fill_line  = '0;
        idle();
        repeat (3) @(negedge clk);
        chk("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
        chk("R2", "req_ready idle", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);

        // R1: no tag valid yet, a write misses
        drive(1'b1, 22'd5, 6'd1, 2'd0, 4'hF, 32'hFFFFFFFF);
        @(negedge clk);
        idle();
        expect_resp("R1", 1'b0, 32'h0);

        // R2: fill blocks a request in the same cycle
        drive(1'b0, 22'd5, 6'd1, 2'd0, 4'h0, 32'h0);
        fill_valid = 1'b1;
        fill_line  = {22'd5, 6'd1};
        #1;
        chk("R2", "req_ready during fill", 32'(req_ready), 32'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        idle();
        chk("R2", "no response to blocked request", 32'(resp_valid), 32'd0);
        fill(22'd7, 6'd2);
        chk("R3", "no response when idle", 32'(resp_valid), 32'd0);

        // Back-to-back stream from the vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].tag, VEC[i].idx, VEC[i].wsel, VEC[i].be, VEC[i].wdata);
            @(negedge clk);
            expect_resp($sformatf("R3 vec%0d", i), VEC[i].exp_hit, VEC[i].exp_rdata);
        end
        idle();
        @(negedge clk);

        // R11: replace the tag of line 1
        fill(22'd9, 6'd1);
        drive(1'b0, 22'd5, 6'd1, 2'd0, 4'h0, 32'h0);
        @(negedge clk);
        expect_resp("R11 old tag", 1'b0, 32'h0);
        drive(1'b0, 22'd9, 6'd1, 2'd0, 4'h0, 32'h0);
        @(negedge clk);
        expect_resp("R11 new tag", 1'b1, 32'h11111111);
        idle();
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule